// File: doc/BRIEF.md
# Masked Priority Interrupt Controller

This block gathers fifteen interrupt requests (a power monitor, a sleep timer, four analog columns, a group of general-purpose I/O lines and eight digital function blocks). Each request is captured as pending on its rising edge. Pending bits are gated by per-source enable bits held in two 8-bit mask registers: one for the general sources and one for the digital blocks. A fixed priority encoder picks the highest-priority source that is both pending and enabled, and turns it into a 16-bit vector. The CPU interrupt request is the OR of all pending-and-enabled bits, gated by a global enable and delayed by one register.

The CPU programs the block through a small synchronous register port. The port has four word addresses, and reads return data combinationally. When the CPU takes an interrupt it pulses `ack_i` and uses `vec_o` in that same cycle. The acknowledge clears only the source that was vectored. If the CPU commits to an interrupt and software then masks the only enabled pending source, the acknowledge sees the null vector 0000h. Any write to the vector address discards every pending request at once.

Top module: `irq_ctrl`

## Requirements
- R1: After reset both mask registers, the global enable (address 3, bit 0), `irq_o` and `vec_o` are all zero, and reads of addresses 0, 1 and 3 return 0.
- R2: A source becomes pending on a 0-to-1 transition of its input. A level that stays high does not make it pending again after it has been cleared.
- R3: Address 0 holds the general mask in bits 6:0, with bit k enabling priority index k (bit 0 power monitor, bit 1 sleep timer, bits 2 to 5 analog columns 0 to 3, bit 6 GPIO). Its bit 7 reads 0. Address 1 holds the digital mask, with bit j enabling digital block j. A 1 enables the source and a 0 disables it, and both registers read back what was written.
- R4: `irq_o` is high in the cycle after one in which the global enable is set and at least one source is both pending and enabled. Otherwise it is low.
- R5: Priority is fixed, from highest to lowest: power monitor, sleep timer, analog 0 to 3, GPIO, then digital 0 to 7. The vector is (index+1)*4: power 04h, sleep 08h, analog k (3+k)*4, GPIO 1Ch, digital j (8+j)*4 (20h to 3Ch).
- R6: `vec_o` gives the vector of the highest-priority pending and enabled source, or 0000h if there is none. A read of address 2 returns the low byte of that vector.
- R7: Any write to address 2 clears every pending bit in the same clock edge.
- R8: `ack_i` clears only the pending bit of the source named by `vec_o` in that cycle.
- R9: An acknowledge taken while no pending source is enabled sees vector 0000h and clears nothing.
- R10: A pending source whose enable bit is clear stays pending and is vectored once it is enabled again.
- R11: A rising edge in the same cycle as a clear, whether a vector write or an acknowledge, leaves that source pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_gen_i | input | 7 | General source requests, bit k = priority index k |
| src_dig_i | input | 8 | Digital block requests, bit j = digital block j |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address (0 general mask, 1 digital mask, 2 vector, 3 control) |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Registered interrupt request to the CPU |
| ack_i | input | 1 | CPU acknowledge, one cycle |
| vec_o | output | 16 | Vector of the highest-priority pending enabled source |

## Verification
A pending bit that is wrongly set or lost shows on `vec_o` in the cycle after the source edge. If the fault is in a bit of lower priority than one already pending, it only shows once the higher sources have been acknowledged, so the bench drains all fifteen sources in order. A fault in the mask or global-enable state shows on `irq_o` one register later. A fault in acknowledge or clear handling shows as a vector that repeats, or one that is skipped, in the next cycle. The corner cases checked are the null vector on a masked acknowledge, held levels, and clears that coincide with new edges.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned N_GEN     = 7;
  localparam int unsigned N_DIG     = 8;
  localparam int unsigned N_SRC     = N_GEN + N_DIG;
  localparam int unsigned SEL_W     = $clog2(N_SRC);
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned VEC_W     = 16;
  localparam int unsigned VEC_SHIFT = 2;

  typedef enum logic [1:0] {
    REG_MSK_GEN = 2'd0,
    REG_MSK_DIG = 2'd1,
    REG_VEC     = 2'd2,
    REG_CTRL    = 2'd3
  } reg_addr_e;

  // index+1 keeps every real source off the null vector
  function automatic logic [VEC_W-1:0] vec_of(input logic [SEL_W-1:0] sel);
    logic [VEC_W-1:0] v;
    v = VEC_W'(sel) + VEC_W'(1);
    return v << VEC_SHIFT;
  endfunction
endpackage

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int unsigned N = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic         clr_all_i,
  input  logic [N-1:0] clr_one_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] edge_o
);
  logic [N-1:0] src_q;
  logic [N-1:0] pend_q;

  for (genvar i = 0; i < N; i++) begin : g_src
    assign edge_o[i] = src_i[i] & ~src_q[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        src_q[i]  <= 1'b0;
        pend_q[i] <= 1'b0;
      end else begin
        src_q[i] <= src_i[i];
        // new edge wins over any clear
        if (edge_o[i])                        pend_q[i] <= 1'b1;
        else if (clr_all_i || clr_one_i[i])   pend_q[i] <= 1'b0;
      end
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N     = 15,
  parameter int unsigned SEL_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             valid_o,
  output logic [SEL_W-1:0] sel_o
);
  // lowest index is highest priority
  always_comb begin
    valid_o = 1'b0;
    sel_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        sel_o   = SEL_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int unsigned NG = N_GEN,
  parameter int unsigned ND = N_DIG,
  parameter int unsigned DW = DATA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [DW-1:0]    vec_lo_i,
  output logic [DW-1:0]    rdata_o,
  output logic [NG+ND-1:0] mask_o,
  output logic             gie_o,
  output logic             clr_all_o
);
  logic [NG-1:0] gen_q;
  logic [ND-1:0] dig_q;
  logic          gie_q;
  reg_addr_e     addr;

  assign addr = reg_addr_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gen_q <= '0;
      dig_q <= '0;
      gie_q <= 1'b0;
    end else if (we_i) begin
      case (addr)
        REG_MSK_GEN: gen_q <= wdata_i[NG-1:0];
        REG_MSK_DIG: dig_q <= wdata_i[ND-1:0];
        REG_CTRL:    gie_q <= wdata_i[0];
        default:     ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      REG_MSK_GEN: rdata_o = DW'(gen_q);
      REG_MSK_DIG: rdata_o = DW'(dig_q);
      REG_VEC:     rdata_o = vec_lo_i;
      default:     rdata_o = DW'(gie_q);
    endcase
  end

  assign clr_all_o = we_i && (addr == REG_VEC);
  assign mask_o    = {dig_q, gen_q};
  assign gie_o     = gie_q;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_GEN-1:0]  src_gen_i,
  input  logic [N_DIG-1:0]  src_dig_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  input  logic              ack_i,
  output logic [VEC_W-1:0]  vec_o
);
  logic [N_SRC-1:0] src_w, pend_w, edge_w, mask_w, req_w, clr_one_w;
  logic             clr_all_w, gie_w, valid_w, irq_q;
  logic [SEL_W-1:0] sel_w;

  assign src_w = {src_dig_i, src_gen_i};

  irq_regs #(.NG(N_GEN), .ND(N_DIG), .DW(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .vec_lo_i  (vec_o[DATA_W-1:0]),
    .rdata_o   (rdata_o),
    .mask_o    (mask_w),
    .gie_o     (gie_w),
    .clr_all_o (clr_all_w)
  );

  irq_pend #(.N(N_SRC)) u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .src_i     (src_w),
    .clr_all_i (clr_all_w),
    .clr_one_i (clr_one_w),
    .pend_o    (pend_w),
    .edge_o    (edge_w)
  );

  assign req_w = pend_w & mask_w;

  irq_prio_enc #(.N(N_SRC), .SEL_W(SEL_W)) u_enc (
    .req_i   (req_w),
    .valid_o (valid_w),
    .sel_o   (sel_w)
  );

  assign vec_o = valid_w ? vec_of(sel_w) : '0;

  for (genvar i = 0; i < N_SRC; i++) begin : g_clr
    assign clr_one_w[i] = ack_i && valid_w && (sel_w == SEL_W'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= gie_w && valid_w;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [1:0]        addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              ack_i,
  input logic              irq_o,
  input logic [VEC_W-1:0]  vec_o,
  input logic [N_SRC-1:0]  pend_i,
  input logic [N_SRC-1:0]  edge_i,
  input logic [N_SRC-1:0]  mask_i,
  input logic              gie_i
);
  // R3
  gen_mask_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd0) |=> (mask_i[N_GEN-1:0] == $past(wdata_i[N_GEN-1:0])));

  // R4
  irq_gie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(gie_i));

  // R5
  vec_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_o != '0) |-> (vec_o[1:0] == 2'b00 && vec_o <= VEC_W'(N_SRC * 4)));

  // R7
  clr_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd2 && edge_i == '0) |=> (pend_i == '0));

  // R8
  ack_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && vec_o != '0 && edge_i == '0 && !(we_i && addr_i == 2'd2))
      |=> ($countones(pend_i) == $countones($past(pend_i)) - 1));

  // R9
  null_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && vec_o == '0 && edge_i == '0 && !(we_i && addr_i == 2'd2))
      |=> (pend_i == $past(pend_i)));
endmodule

bind irq_ctrl irq_ctrl_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .ack_i   (ack_i),
  .irq_o   (irq_o),
  .vec_o   (vec_o),
  .pend_i  (pend_w),
  .edge_i  (edge_w),
  .mask_i  (mask_w),
  .gie_i   (gie_w)
);

// File: tb/irq_ctrl_tb.sv
module irq_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [6:0]  src_gen_i = '0;
  logic [7:0]  src_dig_i = '0;
  logic        we_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        irq_o;
  logic        ack_i = 1'b0;
  logic [15:0] vec_o;

  int checks = 0;
  int errors = 0;

  irq_ctrl u_dut (.*);

  always #4 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    cyc(1);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr_i = a; #1; d = rdata_o;
  endtask

  task automatic pulse(input logic [6:0] g, input logic [7:0] d);
    src_gen_i = g; src_dig_i = d;
    cyc(1);
    src_gen_i = '0; src_dig_i = '0;
  endtask

  task automatic ack();
    ack_i = 1'b1; cyc(1); ack_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(2'd0, d); chk("R1 gen mask", 16'(d), 16'h0);
    rd(2'd1, d); chk("R1 dig mask", 16'(d), 16'h0);
    rd(2'd3, d); chk("R1 ctrl", 16'(d), 16'h0);
    chk("R1 irq", 16'(irq_o), 16'h0);
    chk("R1 vec", vec_o, 16'h0);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    wr(2'd0, 8'hFF); rd(2'd0, d); chk("R3 gen bit7 zero", 16'(d), 16'h7F);
    wr(2'd1, 8'hA5); rd(2'd1, d); chk("R3 dig readback", 16'(d), 16'hA5);
    wr(2'd0, 8'h00); rd(2'd0, d); chk("R3 gen cleared", 16'(d), 16'h00);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_irq_timing();
    wr(2'd3, 8'h01);
    wr(2'd0, 8'h02);
    pulse(7'h02, 8'h00);
    chk("R4 irq one cycle late", 16'(irq_o), 16'h0);
    chk("R6 sleep vector", vec_o, 16'h0008);
    cyc(1);
    chk("R4 irq raised", 16'(irq_o), 16'h1);
    ack();
    chk("R8 ack clears", vec_o, 16'h0);
    cyc(1);
    chk("R4 irq dropped", 16'(irq_o), 16'h0);
    wr(2'd3, 8'h00);
    pulse(7'h02, 8'h00);
    cyc(2);
    chk("R4 gie off blocks irq", 16'(irq_o), 16'h0);
    chk("R4 gie off vector kept", vec_o, 16'h0008);
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h01);
  endtask

  task automatic t_priority();
    logic [7:0] d;
    wr(2'd0, 8'h7F); wr(2'd1, 8'hFF);
    pulse(7'h7F, 8'hFF);
    for (int k = 0; k < 15; k++) begin
      chk($sformatf("R5 order idx %0d", k), vec_o, 16'((k + 1) * 4));
      rd(2'd2, d);
      chk($sformatf("R6 read idx %0d", k), 16'(d), 16'((k + 1) * 4));
      ack();
    end
    chk("R8 all drained", vec_o, 16'h0);
    pulse(7'h40, 8'h08);
    chk("R5 gpio over dig3", vec_o, 16'h001C);
    ack();
    chk("R8 dig3 left", vec_o, 16'h002C);
    ack();
    pulse(7'h04, 8'h00);
    chk("R5 analog0", vec_o, 16'h000C);
    ack();
  endtask

  task automatic t_clear_all();
    logic [7:0] d;
    pulse(7'h15, 8'h81);
    cyc(1);
    chk("R4 irq before clear", 16'(irq_o), 16'h1);
    wr(2'd2, 8'h5A);
    chk("R7 vec after clear", vec_o, 16'h0);
    rd(2'd2, d); chk("R7 read after clear", 16'(d), 16'h0);
    cyc(1);
    chk("R7 irq after clear", 16'(irq_o), 16'h0);
  endtask

  task automatic t_null();
    wr(2'd0, 8'h01); wr(2'd1, 8'h00);
    pulse(7'h01, 8'h00);
    cyc(1);
    chk("R4 power irq", 16'(irq_o), 16'h1);
    wr(2'd0, 8'h00);
    chk("R9 masked vector null", vec_o, 16'h0);
    ack();
    wr(2'd0, 8'h01);
    chk("R9 null ack kept pending", vec_o, 16'h0004);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_masked_keep();
    wr(2'd1, 8'h00); wr(2'd0, 8'h00);
    pulse(7'h00, 8'h20);
    cyc(2);
    chk("R10 masked no irq", 16'(irq_o), 16'h0);
    chk("R10 masked no vec", vec_o, 16'h0);
    wr(2'd1, 8'h20);
    chk("R10 dig5 unmasked", vec_o, 16'h0034);
    ack();
    wr(2'd1, 8'hFF); wr(2'd0, 8'h7F);
  endtask

  task automatic t_level();
    src_gen_i = 7'h40; cyc(1);
    chk("R2 level sets", vec_o, 16'h001C);
    ack();
    cyc(3);
    chk("R2 held level no reset", vec_o, 16'h0);
    src_gen_i = '0; cyc(1);
    chk("R2 fall no set", vec_o, 16'h0);
  endtask

  task automatic t_coincide();
    pulse(7'h40, 8'h00);
    src_dig_i = 8'h01; we_i = 1'b1; addr_i = 2'd2; wdata_i = 8'h00;
    cyc(1);
    we_i = 1'b0; src_dig_i = '0;
    chk("R11 edge beats clear-all", vec_o, 16'h0020);
    src_dig_i = 8'h01;
    cyc(1);
    src_dig_i = 8'h00; cyc(1);
    src_dig_i = 8'h01; ack_i = 1'b1;
    cyc(1);
    ack_i = 1'b0; src_dig_i = '0;
    chk("R11 edge beats ack", vec_o, 16'h0020);
    wr(2'd2, 8'h00);
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    t_reset();
    t_mask();
    t_irq_timing();
    t_priority();
    t_clear_all();
    t_null();
    t_masked_keep();
    t_level();
    t_coincide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule